// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a 32-bit up-counting interval timer for a processor's system bus. Software loads a start value into a reload register, copies it into the running count with a transfer command, and sets run. From then on the count steps by one on every cycle in which the 1 MHz tick enable is high. When the count passes from all ones to zero the timer reloads itself from the reload register, flags completion, and, if enabled, raises a level interrupt. Programming the reload register with the two's complement of a period therefore gives a periodic interrupt at that period.

Completion and a missed completion are kept as separate sticky flags that software clears by writing ones. A stopped timer can also be advanced by hand, one count per control write, which lets software test the overflow path without waiting for ticks. The register interface is a plain single-cycle write strobe with a combinational read; there is no data stream, so every pin is a plain control or status signal with no handshake or back-pressure.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register, the running count, the reload register and the interrupt output are all zero.
- R2: Address 0 is the control register; a read returns error at bit 31, done at bit 7, interrupt enable at bit 6 and run at bit 0, with every other bit zero (bits 5 and 4 are write-only). Address 1 reads the count, address 2 the reload value, and address 3 reads zero.
- R3: The reload register (address 2) is fully writable and readable; a write to the count address (1) leaves the count unchanged.
- R4: With run set, the count grows by exactly one in each cycle where the tick enable is high and holds otherwise; a tick in the same cycle as a control write is discarded.
- R5: A control write with bit 4 set copies the reload register into the count.
- R6: When a tick carries the count from all ones, the count takes the reload value and done is set.
- R7: If done is already set when such an overflow happens, error is set and done stays set.
- R8: On an overflow the interrupt output becomes equal to interrupt enable: raised when enabled, dropped when not.
- R9: A control write clears done when bit 7 is one and error when bit 31 is one, loads interrupt enable and run from bits 6 and 0, and leaves the interrupt output high only if it was already high (or is raised by this write's own overflow) and done and interrupt enable are both set afterwards; a control write never raises the interrupt output by itself otherwise.
- R10: A control write with bit 0 clear and bit 5 set advances the count by one (after any bit-4 transfer in the same write); if that step carries from all ones, the count is reloaded and the step counts as an overflow for done, error and interrupt.
- R11: Writing run as zero stops the count, which then keeps its value and remains readable while ticks continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse at the 1 MHz count rate |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 reload, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is a second overflow while done is still set, since with a real period it takes billions of ticks between wraps. The stimulus reaches it by loading a reload value a few counts below all ones, so each wrap comes within three ticks, and separately by single-stepping a stopped timer through a reload of all ones so that every manual step is an overflow. The corner where a control write and a tick land in the same cycle, and where a transfer and a step share one write, are driven explicitly and compared on every clock against a behavioural model in the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_W    = 32;
  localparam int ERR_BIT  = 31;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int STEP_BIT = 5;
  localparam int XFER_BIT = 4;
  localparam int RUN_BIT  = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic err;
    logic done;
    logic ie;
    logic run;
  } tmr_status_t;
endpackage

// File: rtl/timer_count.sv
module timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] count_d;

  // A transfer in the same write lands before any step.
  always_comb begin
    base    = load ? reload_val : count;
    wrap    = step && (&base);
    count_d = base;
    if (step) count_d = wrap ? reload_val : base + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             wrap,
  output tmr_status_t      stat,
  output logic             irq
);
  tmr_status_t stat_d;
  logic        irq_d;

  always_comb begin
    stat_d = stat;
    irq_d  = irq;
    if (csr_wr) begin
      if (wdata[DONE_BIT]) stat_d.done = 1'b0;
      if (wdata[ERR_BIT])  stat_d.err  = 1'b0;
      stat_d.ie  = wdata[IE_BIT];
      stat_d.run = wdata[RUN_BIT];
    end
    if (wrap) begin
      if (stat_d.done) stat_d.err  = 1'b1;
      else             stat_d.done = 1'b1;
      irq_d = stat_d.ie;
    end
    if (csr_wr) irq_d = irq_d && stat_d.done && stat_d.ie;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_d;
      irq  <= irq_d;
    end
  end
endmodule

// File: rtl/timer_regfile.sv
module timer_regfile
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  tmr_status_t      stat,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic [REG_W-1:0] rdata
);
  localparam int PAD = REG_W - CNT_W;

  logic [REG_W-1:0] count_ext;
  logic [REG_W-1:0] reload_ext;
  logic [REG_W-1:0] ctrl_view;

  generate
    if (PAD > 0) begin : g_pad
      assign count_ext  = {{PAD{1'b0}}, count};
      assign reload_ext = {{PAD{1'b0}}, reload};
    end else begin : g_full
      assign count_ext  = count;
      assign reload_ext = reload;
    end
  endgenerate

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[ERR_BIT]  = stat.err;
    ctrl_view[DONE_BIT] = stat.done;
    ctrl_view[IE_BIT]   = stat.ie;
    ctrl_view[RUN_BIT]  = stat.run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      reload <= '0;
    else if (wr_en && addr == ADDR_RELOAD)
      reload <= wdata[CNT_W-1:0];
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL:   rdata = ctrl_view;
      ADDR_COUNT:  rdata = count_ext;
      ADDR_RELOAD: rdata = reload_ext;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  tmr_status_t      stat;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             csr_wr;
  logic             step;
  logic             load;
  logic             wrap;

  // A control write owns the cycle: its own step decision replaces the tick.
  always_comb begin
    csr_wr = bus_wr && (bus_addr == ADDR_CTRL);
    load   = csr_wr && bus_wdata[XFER_BIT];
    if (csr_wr) step = !bus_wdata[RUN_BIT] && bus_wdata[STEP_BIT];
    else        step = tick_en && stat.run;
  end

  timer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .load       (load),
    .reload_val (reload_q),
    .count      (count_q),
    .wrap       (wrap)
  );

  timer_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .csr_wr (csr_wr),
    .wdata  (bus_wdata),
    .wrap   (wrap),
    .stat   (stat),
    .irq    (irq)
  );

  timer_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .stat   (stat),
    .count  (count_q),
    .reload (reload_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [REG_W-1:0] bus_wdata,
  input logic             irq,
  input tmr_status_t      stat,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q
);
  logic ctl_wr;
  logic manual;
  assign ctl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign manual = !bus_wdata[RUN_BIT] && bus_wdata[STEP_BIT];

  p_tick_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.run && tick_en && !ctl_wr && !(&count_q)) |=> count_q == $past(count_q) + CNT_W'(1));

  p_xfer_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[XFER_BIT] && !manual) |=> count_q == $past(reload_q));

  p_wrap_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.run && tick_en && !ctl_wr && (&count_q)) |=> (count_q == $past(reload_q) && stat.done));

  p_err_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.err) |-> $past(stat.done));

  p_irq_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat.done && stat.ie));

  p_hold_when_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat.run && !ctl_wr) |=> $stable(count_q));
endmodule

bind interval_timer timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .stat      (stat),
  .count_q   (count_q),
  .reload_q  (reload_q)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  bit [31:0] m_cnt, m_rel;
  bit m_err, m_done, m_ie, m_run, m_irq;

  always #5 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return {m_err, 23'd0, m_done, m_ie, 5'd0, m_run};
      2'd1: return m_cnt;
      2'd2: return m_rel;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_clock(input bit wr, input bit [1:0] a, input bit [31:0] d, input bit tk);
    bit advance = 1'b0;
    bit ctl = wr && a == 2'd0;
    bit [31:0] old_rel = m_rel;
    if (ctl) begin
      if (d[7]) m_done = 1'b0;
      if (d[31]) m_err = 1'b0;
      m_ie = d[6];
      m_run = d[0];
      if (d[4]) m_cnt = old_rel;
      advance = !d[0] && d[5];
    end else begin
      advance = tk && m_run;
    end
    if (wr && a == 2'd2) m_rel = d;
    if (advance) begin
      if (m_cnt == 32'hFFFF_FFFF) begin
        m_cnt = old_rel;
        if (m_done) m_err = 1'b1; else m_done = 1'b1;
        m_irq = m_ie;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    if (ctl) m_irq = m_irq && m_done && m_ie;
  endtask

  task automatic compare(input string tag);
    bit [31:0] exp_rd = model_read(bus_addr);
    vectors++;
    if (bus_rdata !== exp_rd) begin
      miscompares++;
      $display("FAIL %s: rdata[addr %0d] actual %h expected %h", tag, bus_addr, bus_rdata, exp_rd);
    end
    vectors++;
    if (irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, m_irq);
    end
  endtask

  // One clock: apply inputs, let the edge pass, update the model, then look.
  task automatic cyc(input bit wr, input bit [1:0] a, input bit [31:0] d, input bit tk,
                     input bit [1:0] look, input string tag);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    model_clock(wr, a, d, tk);
    #2;
    bus_wr = 1'b0; tick_en = 1'b0; bus_addr = look;
    #1;
    compare(tag);
  endtask

  task automatic wr_reg(input bit [1:0] a, input bit [31:0] d, input bit [1:0] look, input string tag);
    cyc(1'b1, a, d, 1'b0, look, tag);
  endtask

  task automatic idle(input bit tk, input bit [1:0] look, input string tag);
    cyc(1'b0, look, 32'd0, tk, look, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    m_cnt = 0; m_rel = 0; m_err = 0; m_done = 0; m_ie = 0; m_run = 0; m_irq = 0;
    // R1 reset state through every address
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1; compare("R1");
    end
    // R3 reload read/write, count address not writable
    wr_reg(2'd2, 32'h1234_5678, 2'd2, "R3");
    wr_reg(2'd1, 32'h0000_DEAD, 2'd1, "R3");
    // R2/R5 all-ones control write: W1C bits, ie, run, transfer; step ignored since run=1
    wr_reg(2'd0, 32'hFFFF_FFFF, 2'd0, "R2");
    idle(1'b0, 2'd1, "R5");
    // R4 ticking with gaps
    for (int i = 0; i < 6; i++) idle(1'(i % 2), 2'd1, "R4");
    // R4 tick lost under a control write
    cyc(1'b1, 2'd0, 32'h0000_0041, 1'b1, 2'd1, "R4");
    // R3 reload write during a tick
    cyc(1'b1, 2'd2, 32'hFFFF_FFFD, 1'b1, 2'd1, "R3");
    // R11 stop and hold
    wr_reg(2'd0, 32'h0000_0000, 2'd1, "R11");
    for (int i = 0; i < 4; i++) idle(1'b1, 2'd1, "R11");
    // R6/R8 overflow with interrupt enable
    wr_reg(2'd0, 32'h0000_0051, 2'd1, "R5");
    for (int i = 0; i < 3; i++) idle(1'b1, 2'd1, "R6");
    idle(1'b0, 2'd0, "R8");
    // R7 second overflow before acknowledge
    for (int i = 0; i < 3; i++) idle(1'b1, 2'd0, "R7");
    // R9 clear error only, done and irq stay
    wr_reg(2'd0, 32'h8000_0041, 2'd0, "R9");
    // R9 clear done and disable: irq drops
    wr_reg(2'd0, 32'h0000_0081, 2'd0, "R9");
    // R8 overflow without enable: done set, irq low
    for (int i = 0; i < 3; i++) idle(1'b1, 2'd0, "R8");
    // R9 enabling with done set does not raise irq
    wr_reg(2'd0, 32'h0000_0041, 2'd0, "R9");
    // R10 single step, then transfer+step through all ones
    wr_reg(2'd0, 32'h0000_00A0, 2'd1, "R10");
    wr_reg(2'd0, 32'h0000_0020, 2'd1, "R10");
    wr_reg(2'd2, 32'hFFFF_FFFF, 2'd1, "R3");
    wr_reg(2'd0, 32'h0000_0030, 2'd0, "R10");
    idle(1'b1, 2'd1, "R10");
    wr_reg(2'd0, 32'h0000_0060, 2'd0, "R10");
    idle(1'b0, 2'd1, "R10");
    // R2 spare address and write-only bits read zero
    idle(1'b0, 2'd3, "R2");
    wr_reg(2'd0, 32'h8000_00B0, 2'd0, "R2");
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule